// File: doc/BRIEF.md
# Windowed Integer Register File

This block stores the integer operands of a processor core. Eight global registers are visible at all times. A circular ring of register windows sits beside them, and each window owns sixteen physical registers: eight "in" registers and eight "local" registers. The active window is chosen by a five-bit pointer. Each window also sees eight "out" registers, which are the same physical cells as the "in" registers of the next window down the ring. When a called routine rotates the pointer, its caller's outgoing arguments therefore appear in its own "in" registers and no data is moved.

One write port and two combinational read ports take 5-bit architectural register numbers. A save command moves the pointer down one window and a restore command moves it up one, both modulo the window count. A per-window invalid mask input guards the rotation. If a command would land on a marked window, the block raises an overflow trap (for a save) or an underflow trap (for a restore) in that same cycle and leaves the pointer where it is. The software trap handler then spills or fills windows. The window count is a parameter from 2 to 32.

Top module: `win_regfile`

## Requirements
- R1: Register numbers 0 to 7 select global storage that is shared by every window. A value written to one of them in any window reads back unchanged in every other window.
- R2: Register numbers 16 to 23 select the active window's locals and 24 to 31 select its ins. A window's locals and ins are private to that window.
- R3: Register numbers 8 to 15 select the outs. Out k of window w is the same cell as in k (register number 24+k) of window (w-1) mod NWIN.
- R4: After reset the pointer reads 0, both traps are low and every register reads 0. The pointer always stays below NWIN.
- R5: A save moves the pointer to (cwp-1) mod NWIN on the next clock edge, so a save from window 0 lands on window NWIN-1.
- R6: A restore moves the pointer to (cwp+1) mod NWIN on the next clock edge, so a restore from window NWIN-1 lands on window 0.
- R7: Bit i of the mask input marks window i as invalid. When a lone save targets a marked window, ovf_trap_o is high in that cycle and the pointer does not move. A lone restore that targets a marked window does the same with unf_trap_o. A marked bit that is not the target has no effect.
- R8: When save and restore are both high in one cycle, the pointer does not move and neither trap is raised, whatever the mask holds.
- R9: Register number 0 always reads 0, and writes to it are discarded.
- R10: A read of the register being written in the same cycle returns the new write data. Other reads return the stored value.
- R11: A write issued in the same cycle as a save or restore lands in the window that was active before the rotation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx_i | input | 5 | Read port A register number |
| rd_a_data_o | output | XLEN | Read port A data (combinational) |
| rd_b_idx_i | input | 5 | Read port B register number |
| rd_b_data_o | output | XLEN | Read port B data (combinational) |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | 5 | Write register number |
| wr_data_i | input | XLEN | Write data |
| save_i | input | 1 | Rotate to the next window down |
| restore_i | input | 1 | Rotate to the next window up |
| wim_i | input | NWIN | Invalid-window mask, one bit per window |
| cwp_o | output | 5 | Current window pointer |
| ovf_trap_o | output | 1 | Save blocked by the mask (same cycle) |
| unf_trap_o | output | 1 | Restore blocked by the mask (same cycle) |

## Verification
A register write and a window rotation can happen in the same clock cycle, and it must be clear which window the write lands in. The bench asserts a write to a local register together with a save. It then restores and reads that local back: the value must appear in the original window and not in the new one. In the same way, a read of the register under write in that cycle must return the incoming data. The bench checks this at the read port before the clock edge, while a second port reads a neighbouring register and must still see the old contents.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  localparam int GLB_CNT = 8;
  localparam int SET_SZ  = 16;
  localparam int IDX_W   = 5;
  localparam int PTR_W   = 5;

  typedef enum logic [1:0] {
    GRP_GLOBAL = 2'd0,
    GRP_OUT    = 2'd1,
    GRP_LOCAL  = 2'd2,
    GRP_IN     = 2'd3
  } reg_grp_e;

  function automatic reg_grp_e grp_of(input logic [IDX_W-1:0] idx);
    return reg_grp_e'(idx[4:3]);
  endfunction

  // pointer one window down the ring (save direction)
  function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p, input int n);
    return (p == '0) ? PTR_W'(n - 1) : p - PTR_W'(1);
  endfunction

  // pointer one window up the ring (restore direction)
  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p, input int n);
    return (p == PTR_W'(n - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  // flat storage layout: globals first, then per window 8 ins then 8 locals
  function automatic int phys_of(input logic [PTR_W-1:0] cwp,
                                 input logic [IDX_W-1:0] idx, input int n);
    int lane;
    lane = int'(idx[2:0]);
    case (grp_of(idx))
      GRP_GLOBAL: return lane;
      GRP_OUT:    return GLB_CNT + int'(ptr_dec(cwp, n)) * SET_SZ + lane;
      GRP_LOCAL:  return GLB_CNT + int'(cwp) * SET_SZ + 8 + lane;
      default:    return GLB_CNT + int'(cwp) * SET_SZ + lane;
    endcase
  endfunction
endpackage

// File: rtl/wrf_window_ctrl.sv
module wrf_window_ctrl #(
  parameter int NWIN = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     save_i,
  input  logic                     restore_i,
  input  logic [NWIN-1:0]          wim_i,
  output logic [wrf_pkg::PTR_W-1:0] cwp_o,
  output logic                     save_go_o,
  output logic                     restore_go_o,
  output logic                     ovf_o,
  output logic                     unf_o
);
  import wrf_pkg::*;

  logic [PTR_W-1:0] cwp_q;
  logic [PTR_W-1:0] tgt_dn;
  logic [PTR_W-1:0] tgt_up;
  logic [31:0]      mask_pad;
  logic             lone_save;
  logic             lone_rest;

  assign mask_pad  = 32'(wim_i);
  assign tgt_dn    = ptr_dec(cwp_q, NWIN);
  assign tgt_up    = ptr_inc(cwp_q, NWIN);
  assign lone_save = save_i & ~restore_i;
  assign lone_rest = restore_i & ~save_i;

  assign ovf_o        = lone_save & mask_pad[tgt_dn];
  assign unf_o        = lone_rest & mask_pad[tgt_up];
  assign save_go_o    = lone_save & ~ovf_o;
  assign restore_go_o = lone_rest & ~unf_o;

  always_ff @(posedge clk) begin
    if (!rst_n)            cwp_q <= '0;
    else if (save_go_o)    cwp_q <= tgt_dn;
    else if (restore_go_o) cwp_q <= tgt_up;
  end

  assign cwp_o = cwp_q;
endmodule

// File: rtl/wrf_addr_map.sv
module wrf_addr_map #(
  parameter int NWIN   = 8,
  parameter int PHYS_W = 8
) (
  input  logic [wrf_pkg::PTR_W-1:0] cwp_i,
  input  logic [wrf_pkg::IDX_W-1:0] idx_i,
  output logic [PHYS_W-1:0]         phys_o
);
  assign phys_o = PHYS_W'(wrf_pkg::phys_of(cwp_i, idx_i, NWIN));
endmodule

// File: rtl/wrf_storage.sv
module wrf_storage #(
  parameter int XLEN   = 32,
  parameter int NREGS  = 136,
  parameter int PHYS_W = 8,
  parameter int NRD    = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we_i,
  input  logic [PHYS_W-1:0]      wphys_i,
  input  logic [XLEN-1:0]        wdata_i,
  input  logic [NRD-1:0][PHYS_W-1:0] rphys_i,
  output logic [NRD-1:0][XLEN-1:0]   rdata_o
);
  logic [XLEN-1:0] mem [NREGS];
  logic            wr_live;

  // physical slot 0 is global 0: never written
  assign wr_live = we_i && (wphys_i != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) mem[i] <= '0;
    end else if (wr_live) begin
      mem[wphys_i] <= wdata_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (rphys_i[p] == '0)                    rdata_o[p] = '0;
      else if (wr_live && wphys_i == rphys_i[p]) rdata_o[p] = wdata_i;
      else                                     rdata_o[p] = mem[rphys_i[p]];
    end
  end
endmodule

// File: rtl/win_regfile.sv
module win_regfile #(
  parameter int NWIN = 8,
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [4:0]      rd_a_idx_i,
  output logic [XLEN-1:0] rd_a_data_o,
  input  logic [4:0]      rd_b_idx_i,
  output logic [XLEN-1:0] rd_b_data_o,
  input  logic            wr_en_i,
  input  logic [4:0]      wr_idx_i,
  input  logic [XLEN-1:0] wr_data_i,
  input  logic            save_i,
  input  logic            restore_i,
  input  logic [NWIN-1:0] wim_i,
  output logic [4:0]      cwp_o,
  output logic            ovf_trap_o,
  output logic            unf_trap_o
);
  localparam int NREGS  = wrf_pkg::GLB_CNT + NWIN * wrf_pkg::SET_SZ;
  localparam int PHYS_W = $clog2(NREGS);
  localparam int NPORT  = 3;  // 0: write, 1: read A, 2: read B

  logic [4:0]        cwp;
  logic              save_go;
  logic              restore_go;
  logic              ovf_hit;
  logic              unf_hit;
  logic [4:0]        port_idx  [NPORT];
  logic [PHYS_W-1:0] port_phys [NPORT];
  logic [1:0][PHYS_W-1:0] rd_phys;
  logic [1:0][XLEN-1:0]   rd_data;

  wrf_window_ctrl #(.NWIN(NWIN)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .save_i       (save_i),
    .restore_i    (restore_i),
    .wim_i        (wim_i),
    .cwp_o        (cwp),
    .save_go_o    (save_go),
    .restore_go_o (restore_go),
    .ovf_o        (ovf_hit),
    .unf_o        (unf_hit)
  );

  assign port_idx[0] = wr_idx_i;
  assign port_idx[1] = rd_a_idx_i;
  assign port_idx[2] = rd_b_idx_i;

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    wrf_addr_map #(.NWIN(NWIN), .PHYS_W(PHYS_W)) u_map (
      .cwp_i  (cwp),
      .idx_i  (port_idx[p]),
      .phys_o (port_phys[p])
    );
  end

  assign rd_phys[0] = port_phys[1];
  assign rd_phys[1] = port_phys[2];

  wrf_storage #(.XLEN(XLEN), .NREGS(NREGS), .PHYS_W(PHYS_W), .NRD(2)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (wr_en_i),
    .wphys_i (port_phys[0]),
    .wdata_i (wr_data_i),
    .rphys_i (rd_phys),
    .rdata_o (rd_data)
  );

  assign rd_a_data_o = rd_data[0];
  assign rd_b_data_o = rd_data[1];
  assign cwp_o       = cwp;
  assign ovf_trap_o  = ovf_hit;
  assign unf_trap_o  = unf_hit;
endmodule

// File: rtl/win_regfile_chk.sv
module win_regfile_chk #(
  parameter int NWIN = 8,
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            save_i,
  input logic            restore_i,
  input logic [4:0]      cwp_o,
  input logic            ovf_trap_o,
  input logic            unf_trap_o,
  input logic            save_go,
  input logic            restore_go,
  input logic [4:0]      rd_a_idx_i,
  input logic [XLEN-1:0] rd_a_data_o,
  input logic            wr_en_i,
  input logic [4:0]      wr_idx_i,
  input logic [XLEN-1:0] wr_data_i
);
  import wrf_pkg::*;

  AST_CWP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cwp_o < 5'(NWIN)); // R4
  AST_SAVE_ROTATES: assert property (@(posedge clk) disable iff (!rst_n)
    save_go |=> cwp_o == ptr_dec($past(cwp_o), NWIN)); // R5
  AST_RESTORE_ROTATES: assert property (@(posedge clk) disable iff (!rst_n)
    restore_go |=> cwp_o == ptr_inc($past(cwp_o), NWIN)); // R6
  AST_TRAP_FREEZES_CWP: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_trap_o || unf_trap_o) |=> $stable(cwp_o)); // R7
  AST_OVF_FROM_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_trap_o |-> (save_i && !restore_i && !save_go)); // R7
  AST_UNF_FROM_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    unf_trap_o |-> (restore_i && !save_i && !restore_go)); // R7
  AST_BOTH_CMDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (save_i && restore_i) |=> $stable(cwp_o)); // R8
  AST_BOTH_CMDS_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (save_i && restore_i) |-> !(ovf_trap_o || unf_trap_o)); // R8
  AST_G0_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_idx_i == 5'd0 |-> rd_a_data_o == '0); // R9
  AST_WRITE_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_idx_i != 5'd0 && wr_idx_i == rd_a_idx_i) |-> rd_a_data_o == wr_data_i); // R10
endmodule

bind win_regfile win_regfile_chk #(.NWIN(NWIN), .XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .save_i      (save_i),
  .restore_i   (restore_i),
  .cwp_o       (cwp_o),
  .ovf_trap_o  (ovf_trap_o),
  .unf_trap_o  (unf_trap_o),
  .save_go     (save_go),
  .restore_go  (restore_go),
  .rd_a_idx_i  (rd_a_idx_i),
  .rd_a_data_o (rd_a_data_o),
  .wr_en_i     (wr_en_i),
  .wr_idx_i    (wr_idx_i),
  .wr_data_i   (wr_data_i)
);

// File: tb/win_regfile_tb_top.sv
module win_regfile_tb_top;
  localparam int N    = 4;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [4:0]      rd_a_idx, rd_b_idx, wr_idx, cwp;
  logic [XLEN-1:0] rd_a_data, rd_b_data, wr_data;
  logic            wr_en, save, restore, ovf, unf;
  logic [N-1:0]    wim;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  // bench model: globals, and per window ins and locals
  logic [XLEN-1:0] m_glb [8];
  logic [XLEN-1:0] m_in  [N][8];
  logic [XLEN-1:0] m_loc [N][8];
  int mw = 0;

  always #10 clk = ~clk;

  win_regfile #(.NWIN(N), .XLEN(XLEN)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx_i(rd_a_idx), .rd_a_data_o(rd_a_data),
    .rd_b_idx_i(rd_b_idx), .rd_b_data_o(rd_b_data),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .save_i(save), .restore_i(restore), .wim_i(wim),
    .cwp_o(cwp), .ovf_trap_o(ovf), .unf_trap_o(unf)
  );

  function automatic int below(int w); return (w + N - 1) % N; endfunction
  function automatic int above(int w); return (w + 1) % N; endfunction

  function automatic logic [XLEN-1:0] m_read(int w, int r);
    if (r == 0)       return '0;
    else if (r < 8)   return m_glb[r];
    else if (r < 16)  return m_in[below(w)][r - 8];
    else if (r < 24)  return m_loc[w][r - 16];
    else              return m_in[w][r - 24];
  endfunction

  task automatic m_write(int w, int r, logic [XLEN-1:0] d);
    if (r == 0) return;
    else if (r < 8)  m_glb[r] = d;
    else if (r < 16) m_in[below(w)][r - 8] = d;
    else if (r < 24) m_loc[w][r - 16] = d;
    else             m_in[w][r - 24] = d;
  endtask

  function automatic string tag_of(int r);
    if (r < 8)       return "R1";
    else if (r < 16) return "R3";
    else             return "R2";
  endfunction

  task automatic chk(string req, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; save = 0; restore = 0; wim = '0;
    wr_idx = 0; wr_data = '0; rd_a_idx = 0; rd_b_idx = 0;
  endtask

  // inputs are set at a negedge; this advances through one rising edge
  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_write(int r, logic [XLEN-1:0] d);
    wr_en = 1; wr_idx = 5'(r); wr_data = d; tick();
    m_write(mw, r, d); idle();
  endtask

  task automatic do_save(string req);
    save = 1; tick(); idle();
    mw = below(mw);
    chk(req, "cwp after save", 32'(cwp), 32'(mw));
  endtask

  task automatic do_restore(string req);
    restore = 1; tick(); idle();
    mw = above(mw);
    chk(req, "cwp after restore", 32'(cwp), 32'(mw));
  endtask

  task automatic read_window(int w);
    for (int r = 0; r < 32; r++) begin
      rd_a_idx = 5'(r); rd_b_idx = 5'(31 - r); #1;
      chk(tag_of(r), $sformatf("win %0d portA r%0d", w, r), rd_a_data, m_read(w, r));
      chk(tag_of(31 - r), $sformatf("win %0d portB r%0d", w, 31 - r), rd_b_data, m_read(w, 31 - r));
    end
    idle();
  endtask

  initial begin
    #(20 * 150000);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    if (!done) $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [XLEN-1:0] v;
    for (int i = 0; i < 8; i++) m_glb[i] = '0;
    for (int w = 0; w < N; w++)
      for (int i = 0; i < 8; i++) begin m_in[w][i] = '0; m_loc[w][i] = '0; end
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R4", "cwp at reset", 32'(cwp), 32'd0);
    chk("R4", "traps at reset", {30'd0, ovf, unf}, 32'd0);
    read_window(0);

    // sweep: fill every register from every window, rotating upward (R6 wrap)
    for (int pass = 0; pass < N; pass++) begin
      for (int r = 1; r < 32; r++)
        do_write(r, 32'h5A000000 | (pass << 16) | (r << 8) | mw);
      do_restore("R6");
    end
    // read back every window, rotating downward (R5 wrap from 0)
    for (int k = 0; k < N; k++) begin
      read_window(mw);
      do_save("R5");
    end

    // R3: out written in window c appears as in of window c-1
    do_write(9, 32'hC0FFEE09);
    do_save("R5");
    rd_a_idx = 5'd25; #1;
    chk("R3", "caller out r9 seen as callee in r25", rd_a_data, 32'hC0FFEE09);
    idle();
    do_restore("R6");

    // R9: global 0
    do_write(0, 32'hFFFFFFFF);
    rd_a_idx = 0; #1;
    chk("R9", "r0 after write", rd_a_data, 32'd0);
    wr_en = 1; wr_idx = 0; wr_data = 32'h12345678; rd_b_idx = 0; #1;
    chk("R9", "r0 read during write", rd_b_data, 32'd0);
    tick(); idle();

    // R10: same-cycle bypass, neighbour reads stored value
    wr_en = 1; wr_idx = 5'd17; wr_data = 32'hB1B2B3B4; rd_a_idx = 5'd17; rd_b_idx = 5'd18; #1;
    chk("R10", "bypass r17", rd_a_data, 32'hB1B2B3B4);
    chk("R10", "neighbour r18", rd_b_data, m_read(mw, 18));
    tick(); m_write(mw, 17, 32'hB1B2B3B4); idle();
    rd_a_idx = 5'd17; #1;
    chk("R10", "r17 stored", rd_a_data, 32'hB1B2B3B4);
    idle();

    // R11: write in the cycle of a save lands in the old window
    v = 32'h0DD0BEEF;
    wr_en = 1; wr_idx = 5'd20; wr_data = v; save = 1;
    tick(); m_write(mw, 20, v); idle();
    mw = below(mw);
    chk("R11", "cwp after save with write", 32'(cwp), 32'(mw));
    rd_a_idx = 5'd20; #1;
    chk("R11", "new window local untouched", rd_a_data, m_read(mw, 20));
    idle();
    do_restore("R11");
    rd_a_idx = 5'd20; #1;
    chk("R11", "old window local holds write", rd_a_data, v);
    idle();

    // R7: mask blocks save and restore
    wim = N'(1) << below(mw); save = 1; #1;
    chk("R7", "ovf on blocked save", {30'd0, ovf, unf}, 32'd2);
    tick(); idle();
    chk("R7", "cwp held after ovf", 32'(cwp), 32'(mw));
    wim = N'(1) << above(mw); restore = 1; #1;
    chk("R7", "unf on blocked restore", {30'd0, ovf, unf}, 32'd1);
    tick(); idle();
    chk("R7", "cwp held after unf", 32'(cwp), 32'(mw));
    wim = N'(1) << mw; save = 1; #1;
    chk("R7", "non-target mask bit no trap", {30'd0, ovf, unf}, 32'd0);
    tick(); idle(); mw = below(mw);
    chk("R7", "save proceeds", 32'(cwp), 32'(mw));
    do_restore("R6");

    // R8: both commands together
    save = 1; restore = 1; #1;
    chk("R8", "no trap clear mask", {30'd0, ovf, unf}, 32'd0);
    tick(); idle();
    chk("R8", "cwp held clear mask", 32'(cwp), 32'(mw));
    save = 1; restore = 1; wim = '1; #1;
    chk("R8", "no trap full mask", {30'd0, ovf, unf}, 32'd0);
    tick(); idle();
    chk("R8", "cwp held full mask", 32'(cwp), 32'(mw));

    // final consistency sweep of all windows
    for (int k = 0; k < N; k++) begin
      read_window(mw);
      do_restore("R6");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule